// File: doc/BRIEF.md
# Multi-Mode Add Control Sequencer

This block is the hardwired control unit that steps a single-bus processor through one add instruction. The operand is supplied in one of three ways: immediate, absolute or indirect. A step counter selects one step of a merged control sequence. Each step drives a bundle of register gate enables, a memory read request, an ALU input select, the add command, a wait-for-memory request and an end marker. The operand mode is taken from a two-bit field of the instruction register.

The three modes share a single twelve-step sequence. Immediate and absolute operands jump ahead to the common tail by loading the counter with step 10. Memory waits depend on the memory-function-complete input. The counter holds only while a read is still outstanding, so a reply that has already arrived costs no cycle. The End step sends the counter back to step 1.

Top module: `add_mode_sequencer`

## Requirements
- R1: While rst_ni is low and on the first cycle after release, step_o is 1 and ctrl_o carries the step-1 bundle.
- R2: ctrl_o bit map is 0 pc_out, 1 pc_in, 2 mar_in, 3 mdr_out, 4 ir_in, 5 y_in, 6 z_in, 7 z_out, 8 r1_out, 9 r1_in, 10 read, 11 sel_four, 12 sel_y, 13 add, 14 wait_mem, 15 done. Step 1 drives pc_out, mar_in, read, sel_four, add and z_in. Step 2 drives z_out, pc_in, y_in and wait_mem. Step 3 drives mdr_out and ir_in.
- R3: Step 4 drives the same bits as step 1, and step 5 drives z_out and pc_in. Mode 00 is immediate; with it, step 5 is followed by step 10.
- R4: Step 6 drives wait_mem only. Step 7 drives mdr_out, mar_in and read. Mode 01 is absolute; with it, step 7 is followed by step 10.
- R5: Modes 10 and 11 are indirect and pass through step 8 (wait_mem only) and step 9 (mdr_out, mar_in, read) before step 10.
- R6: Step 10 drives r1_out, y_in and wait_mem. Step 11 drives mdr_out, sel_y, add and z_in. Step 12 drives z_out, r1_in and done.
- R7: The counter changes only at an edge where the run condition is true. On a stalled cycle, step_o and ctrl_o repeat.
- R8: A wait_mem step stalls while a read is outstanding and mfc_i is low. It advances at the end of the cycle in which mfc_i is high, so it lasts exactly as many cycles as the reply takes to arrive.
- R9: After a step with done set, the next step is 1.
- R10: A read whose mfc_i pulse arrives before the wait_mem step that follows it causes no stall: that wait step lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operand mode field from the instruction register |
| mfc_i | input | 1 | Memory-function-complete pulse |
| ctrl_o | output | 16 | Control signal bundle for the current step |
| step_o | output | 4 | Current step number, 1 to 12 |

## Verification
All four mode codes are run back to back with memory reply latencies of one to four cycles, and every cycle's bundle and step number is compared. The mode sweep tells the three branch paths apart and confirms that code 11 behaves as indirect. The latency sweep separates a wait that has to stall from one whose reply came early. With a one-cycle latency, step 10 in immediate mode and step 6 complete at once. With longer latencies they stretch by a known number of cycles.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int STEP_W   = 4;
  localparam int CTRL_W   = 16;
  localparam logic [STEP_W-1:0] FIRST_STEP = 4'd1;
  localparam logic [STEP_W-1:0] JOIN_STEP  = 4'd10;
  localparam logic [STEP_W-1:0] LAST_STEP  = 4'd12;

  localparam int B_PC_OUT  = 0;
  localparam int B_PC_IN   = 1;
  localparam int B_MAR_IN  = 2;
  localparam int B_MDR_OUT = 3;
  localparam int B_IR_IN   = 4;
  localparam int B_Y_IN    = 5;
  localparam int B_Z_IN    = 6;
  localparam int B_Z_OUT   = 7;
  localparam int B_R1_OUT  = 8;
  localparam int B_R1_IN   = 9;
  localparam int B_READ    = 10;
  localparam int B_SEL4    = 11;
  localparam int B_SELY    = 12;
  localparam int B_ADD     = 13;
  localparam int B_WAIT    = 14;
  localparam int B_DONE    = 15;

  typedef enum logic [1:0] {
    MODE_IMM  = 2'b00,
    MODE_ABS  = 2'b01,
    MODE_IND  = 2'b10,
    MODE_IND2 = 2'b11
  } mode_e;

  typedef logic [CTRL_W-1:0] ctrl_t;
endpackage

// File: rtl/step_decoder.sv
module step_decoder
  import seq_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  input  logic [1:0]        mode_i,
  output ctrl_t             ctrl_o,
  output logic              br_o
);
  ctrl_t fetch_bits;

  always_comb begin
    fetch_bits = '0;
    fetch_bits[B_PC_OUT] = 1'b1;
    fetch_bits[B_MAR_IN] = 1'b1;
    fetch_bits[B_READ]   = 1'b1;
    fetch_bits[B_SEL4]   = 1'b1;
    fetch_bits[B_ADD]    = 1'b1;
    fetch_bits[B_Z_IN]   = 1'b1;
  end

  always_comb begin
    ctrl_o = '0;
    br_o   = 1'b0;
    unique case (step_i)
      4'd1, 4'd4: ctrl_o = fetch_bits;
      4'd2: begin
        ctrl_o[B_Z_OUT] = 1'b1;
        ctrl_o[B_PC_IN] = 1'b1;
        ctrl_o[B_Y_IN]  = 1'b1;
        ctrl_o[B_WAIT]  = 1'b1;
      end
      4'd3: begin
        ctrl_o[B_MDR_OUT] = 1'b1;
        ctrl_o[B_IR_IN]   = 1'b1;
      end
      4'd5: begin
        ctrl_o[B_Z_OUT] = 1'b1;
        ctrl_o[B_PC_IN] = 1'b1;
        br_o = (mode_i == MODE_IMM);
      end
      4'd6, 4'd8: ctrl_o[B_WAIT] = 1'b1;
      4'd7, 4'd9: begin
        ctrl_o[B_MDR_OUT] = 1'b1;
        ctrl_o[B_MAR_IN]  = 1'b1;
        ctrl_o[B_READ]    = 1'b1;
        br_o = (step_i == 4'd7) && (mode_i == MODE_ABS);
      end
      4'd10: begin
        ctrl_o[B_R1_OUT] = 1'b1;
        ctrl_o[B_Y_IN]   = 1'b1;
        ctrl_o[B_WAIT]   = 1'b1;
      end
      4'd11: begin
        ctrl_o[B_MDR_OUT] = 1'b1;
        ctrl_o[B_SELY]    = 1'b1;
        ctrl_o[B_ADD]     = 1'b1;
        ctrl_o[B_Z_IN]    = 1'b1;
      end
      4'd12: begin
        ctrl_o[B_Z_OUT] = 1'b1;
        ctrl_o[B_R1_IN] = 1'b1;
        ctrl_o[B_DONE]  = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mem_wait_tracker.sv
module mem_wait_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic read_i,
  input  logic wait_i,
  input  logic mfc_i,
  output logic run_o,
  output logic pending_o
);
  logic pending_d;

  always_comb begin
    pending_d = pending_o;
    if (mfc_i)  pending_d = 1'b0;
    if (read_i) pending_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_o <= 1'b0;
    else         pending_o <= pending_d;
  end

  assign run_o = !(wait_i && pending_o && !mfc_i);

  // R10: a completed reply clears the outstanding flag
  p_reply_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mfc_i && !read_i) |=> !pending_o);
  // R8: with nothing outstanding a wait never holds the counter
  p_no_idle_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_o) |-> run_o);
endmodule

// File: rtl/step_counter.sv
module step_counter
  import seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              done_i,
  input  logic              br_i,
  output logic [STEP_W-1:0] step_o
);
  logic [STEP_W-1:0] step_d;
  logic              step_en;

  assign step_en = run_i;

  always_comb begin
    if (done_i)    step_d = FIRST_STEP;
    else if (br_i) step_d = JOIN_STEP;
    else           step_d = step_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      step_o <= FIRST_STEP;
    else if (step_en) step_o <= step_d;
  end

  // R7: the step stays within the sequence
  p_step_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o >= FIRST_STEP) && (step_o <= LAST_STEP));
  // R7: no change without run
  p_hold_on_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i) |=> $stable(step_o));
endmodule

// File: rtl/add_mode_sequencer.sv
module add_mode_sequencer
  import seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              mfc_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [STEP_W-1:0] step_o
);
  ctrl_t ctrl;
  logic  br, run, pending;

  step_decoder u_dec (
    .step_i (step_o),
    .mode_i (mode_i),
    .ctrl_o (ctrl),
    .br_o   (br)
  );

  mem_wait_tracker u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .read_i    (ctrl[B_READ]),
    .wait_i    (ctrl[B_WAIT]),
    .mfc_i     (mfc_i),
    .run_o     (run),
    .pending_o (pending)
  );

  step_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .done_i (ctrl[B_DONE]),
    .br_i   (br),
    .step_o (step_o)
  );

  assign ctrl_o = ctrl;

  // R3: immediate mode jumps from step 5 to the common tail
  p_imm_branch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == 4'd5 && mode_i == MODE_IMM) |=> (step_o == JOIN_STEP));
  // R4: absolute mode jumps from step 7 to the common tail
  p_abs_branch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == 4'd7 && mode_i == MODE_ABS) |=> (step_o == JOIN_STEP));
  // R9: done returns the counter to the first step
  p_end_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[B_DONE] |=> (step_o == FIRST_STEP));
  // R8: a wait with the reply present advances
  p_reply_releases_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[B_WAIT] && mfc_i) |=> (step_o != $past(step_o)));
endmodule

// File: tb/add_mode_sequencer_tb_top.sv
module add_mode_sequencer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        mfc_i = 1'b0;
  logic [15:0] ctrl_o;
  logic [3:0]  step_o;

  int total = 0;
  int bad   = 0;
  int lat   = 1;
  int cnt   = 0;
  bit fin   = 0;

  add_mode_sequencer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .mfc_i(mfc_i), .ctrl_o(ctrl_o), .step_o(step_o)
  );

  always #4 clk_i = ~clk_i;

  // memory model: pulse mfc_i lat cycles after the read cycle
  always @(negedge clk_i) begin
    #1;
    mfc_i = (cnt == 1);
    if (cnt > 0) cnt = cnt - 1;
    if (rst_ni && ctrl_o[10]) cnt = lat;
  end

  function automatic logic [15:0] bits(input int s);
    logic [15:0] b = '0;
    case (s)
      1, 4: begin b[0]=1; b[2]=1; b[10]=1; b[11]=1; b[13]=1; b[6]=1; end
      2:  begin b[7]=1; b[1]=1; b[5]=1; b[14]=1; end
      3:  begin b[3]=1; b[4]=1; end
      5:  begin b[7]=1; b[1]=1; end
      6, 8: b[14]=1;
      7, 9: begin b[3]=1; b[2]=1; b[10]=1; end
      10: begin b[8]=1; b[5]=1; b[14]=1; end
      11: begin b[3]=1; b[12]=1; b[13]=1; b[6]=1; end
      12: begin b[7]=1; b[9]=1; b[15]=1; end
      default: b = '0;
    endcase
    return b;
  endfunction

  function automatic string tag(input int s);
    if (s <= 3) return "R2";
    if (s <= 5) return "R3";
    if (s <= 7) return "R4";
    if (s <= 9) return "R5";
    return "R6";
  endfunction

  task automatic check(input int s, input string t);
    total++;
    if (step_o !== s[3:0] || ctrl_o !== bits(s)) begin
      bad++;
      $display("FAIL %s: step=%0d ctrl=%h expected step=%0d ctrl=%h",
               t, step_o, ctrl_o, s, bits(s));
    end
  endtask

  task automatic run_instr(input int m, input int l);
    int path[$];
    mode_i = m[1:0];
    lat    = l;
    if (m == 0)      path = '{1,2,3,4,5,10,11,12};
    else if (m == 1) path = '{1,2,3,4,5,6,7,10,11,12};
    else             path = '{1,2,3,4,5,6,7,8,9,10,11,12};
    foreach (path[i]) begin
      int s = path[i];
      int dur = 1;
      bit early = 0;
      if (s == 2 || s == 8) dur = l;
      if (s == 6) begin dur = (l > 1) ? l - 1 : 1; early = 1; end
      if (s == 10) begin
        if (m == 0) begin dur = (l > 1) ? l - 1 : 1; early = 1; end
        else dur = l;
      end
      for (int c = 0; c < dur; c++) begin
        #1;
        if (c > 0) check(s, "R7 R8 stall");
        else if (early && dur == 1) check(s, "R10 early reply");
        else if (i == 0) check(s, "R9 wrap");
        else check(s, tag(s));
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    #2000000;
    if (!fin) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, "R1 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1 check(1, "R1 release");
    for (int m = 0; m < 4; m++)
      for (int l = 1; l <= 4; l++)
        run_instr(m, l);
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule